// File: doc/BRIEF.md
# Multi-Lane Fast-Read Output Path

This block is the read-data path of a serial flash slave for two-lane and four-lane fast reads. It watches the serial clock and chip select, takes in the command byte and the start address, and sits out a fixed dummy window. It then sends bytes from a simple synchronous read port on two or four bidirectional pins.

The lane count is picked per command from a fixed opcode set. The four-lane commands only open when a quad-enable input is set. When the four-lane set is enabled, the pins that normally carry write-protect and hold become data lanes. The block then reports those two functions as inactive to the rest of the device.

The block runs on a fast system clock. The pin signals are resynchronised and the serial clock edges are found by edge detection, so every pin result reaches the outputs a fixed number of system cycles after the serial edge that causes it.

Top module: `qread_lane_io`

## Requirements
- R1: The command byte is taken from pin 0 on serial-clock rising edges, MSB first. Codes 3Bh and BBh pick two lanes, codes 6Bh, EBh, E7h and E3h pick four lanes. Any other code leaves `pin_oe` at 0 until chip select rises.
- R2: When `quad_en` is 0 while the command byte completes, a four-lane code leaves `pin_oe` at 0 for the whole transaction.
- R3: The 24-bit start address follows MSB first. It takes 24 clocks on pin 0 for 3Bh and 6Bh, 12 clocks on pins 1:0 for BBh (higher bit on pin 1), and 6 clocks on pins 3:0 for EBh, E7h and E3h (highest bit on pin 3).
- R4: `pin_oe` stays 0 through the command, the address and 8 dummy clocks. It becomes 4'b0011 (two lanes) or 4'b1111 (four lanes) from the first falling edge after the last dummy rising edge, and takes no other nonzero value.
- R5: In two-lane output, the four clocks of a byte carry bits [7:6], [5:4], [3:2] and [1:0], with the higher bit of each pair on pin 1.
- R6: In four-lane output, a byte takes two clocks, bits [7:4] and then [3:0], with bit 7 on pin 3.
- R7: Bytes come from consecutive addresses starting at the received address and wrapping at 24 bits. Each byte is fetched by a one-cycle `rd_req` with `rd_addr`, and `rd_data` is taken on the following system cycle.
- R8: When chip select rises, `pin_oe` returns to 0 within 4 system cycles, even in the middle of a byte. The next transaction starts clean.
- R9: `wp_n_eff` and `hold_n_eff` follow pins 2 and 3 when `quad_en` is 0, and are held at 1 (inactive) when `quad_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| quad_en | input | 1 | Non-volatile enable for four-lane commands |
| spi_sck | input | 1 | Serial clock pin |
| spi_cs_n | input | 1 | Chip select pin, active low |
| pin_in | input | 4 | Input value of pins 0..3 (data-in, data-out, write-protect, hold) |
| pin_out | output | 4 | Output value for pins 0..3 |
| pin_oe | output | 4 | Output enable for pins 0..3 |
| wp_n_eff | output | 1 | Effective write-protect level for the device, active low |
| hold_n_eff | output | 1 | Effective hold level for the device, active low |
| rd_req | output | 1 | One-cycle read request to the byte source |
| rd_addr | output | 24 | Byte address of the request |
| rd_data | input | 8 | Byte returned one cycle after the request |

## Verification
Every pin input passes two synchroniser stages and one output register. So `pin_out` and `pin_oe` settle three system cycles after a serial falling edge, `pin_oe` clears three cycles after chip select rises, and the effective write-protect and hold levels follow their pins or `quad_en` after three cycles. The bench holds each serial clock level for six system cycles and samples the pins just before it drives a rising edge, as a bus master would. That sample lands three cycles after the outputs have settled. Release and write-protect or hold results are sampled four cycles after the stimulus. Byte fetches are checked through the data that appears on the pins, since a wrong address or a late capture shows up as a wrong lane value.

// File: rtl/qread_pkg.sv
package qread_pkg;

  typedef enum logic [1:0] {
    LM_NONE = 2'd0,
    LM_DUAL = 2'd1,
    LM_QUAD = 2'd2
  } lane_mode_t;

  typedef struct packed {
    lane_mode_t data_mode;
    logic [2:0] addr_lanes;
  } cmd_info_t;

  // Command code to lane plan; four-lane codes need the enable bit.
  function automatic cmd_info_t decode_cmd(input logic [7:0] op, input logic qe);
    cmd_info_t ci;
    ci.data_mode  = LM_NONE;
    ci.addr_lanes = 3'd1;
    case (op)
      8'h3B: ci.data_mode = LM_DUAL;
      8'hBB: begin
        ci.data_mode  = LM_DUAL;
        ci.addr_lanes = 3'd2;
      end
      8'h6B: if (qe) ci.data_mode = LM_QUAD;
      8'hEB, 8'hE7, 8'hE3: if (qe) begin
        ci.data_mode  = LM_QUAD;
        ci.addr_lanes = 3'd4;
      end
      default: ci.data_mode = LM_NONE;
    endcase
    return ci;
  endfunction

  // Lane value for group grp of a byte, high bits first.
  function automatic logic [3:0] lane_slice(input logic [7:0] b, input logic [1:0] grp,
                                            input lane_mode_t m);
    logic [7:0] sh;
    logic [3:0] res;
    res = 4'b0000;
    if (m == LM_QUAD) begin
      sh  = b << {grp, 2'b00};
      res = sh[7:4];
    end else if (m == LM_DUAL) begin
      sh  = b << {grp, 1'b0};
      res = {2'b00, sh[7:6]};
    end
    return res;
  endfunction

  function automatic logic [3:0] oe_mask(input lane_mode_t m);
    return (m == LM_QUAD) ? 4'b1111 : (m == LM_DUAL) ? 4'b0011 : 4'b0000;
  endfunction

  function automatic logic [1:0] last_group(input lane_mode_t m);
    return (m == LM_QUAD) ? 2'd1 : 2'd3;
  endfunction

endpackage

// File: rtl/qread_sync.sv
module qread_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qread_cmd_track.sv
module qread_cmd_track
  import qread_pkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter int DUMMY_CYC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_s,
  input  logic                 rise,
  input  logic [3:0]           lanes,
  input  logic                 quad_en,
  output lane_mode_t           mode,
  output logic                 data_phase,
  output logic                 start,
  output logic [ADDR_BITS-1:0] start_addr
);
  localparam int CNT_W = $clog2(ADDR_BITS + DUMMY_CYC + 1);

  typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA, PH_SKIP} phase_t;

  phase_t               phase;
  logic [CNT_W-1:0]     cnt;
  logic [7:0]           opc_sh;
  logic [ADDR_BITS-1:0] addr_sh;
  logic [2:0]           addr_lanes;
  logic [CNT_W-1:0]     addr_last;
  logic [ADDR_BITS-1:0] addr_next;
  logic [7:0]           opc_next;
  cmd_info_t            info;

  assign opc_next = {opc_sh[6:0], lanes[0]};
  assign info     = decode_cmd(opc_next, quad_en);

  always_comb begin
    case (addr_lanes)
      3'd2:    addr_last = CNT_W'(ADDR_BITS / 2 - 1);
      3'd4:    addr_last = CNT_W'(ADDR_BITS / 4 - 1);
      default: addr_last = CNT_W'(ADDR_BITS - 1);
    endcase
    case (addr_lanes)
      3'd2:    addr_next = {addr_sh[ADDR_BITS-3:0], lanes[1:0]};
      3'd4:    addr_next = {addr_sh[ADDR_BITS-5:0], lanes[3:0]};
      default: addr_next = {addr_sh[ADDR_BITS-2:0], lanes[0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      phase      <= PH_OPC;
      cnt        <= '0;
      opc_sh     <= '0;
      addr_sh    <= '0;
      addr_lanes <= 3'd1;
      mode       <= LM_NONE;
      start      <= 1'b0;
      start_addr <= '0;
    end else begin
      start <= 1'b0;
      if (rise) begin
        case (phase)
          PH_OPC: begin
            opc_sh <= opc_next;
            if (cnt == CNT_W'(7)) begin
              cnt        <= '0;
              mode       <= info.data_mode;
              addr_lanes <= info.addr_lanes;
              phase      <= (info.data_mode == LM_NONE) ? PH_SKIP : PH_ADDR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_ADDR: begin
            addr_sh <= addr_next;
            if (cnt == addr_last) begin
              cnt        <= '0;
              phase      <= PH_DUMMY;
              start      <= 1'b1;
              start_addr <= addr_next;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DUMMY: begin
            if (cnt == CNT_W'(DUMMY_CYC - 1)) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: phase <= phase;
        endcase
      end
    end
  end

  assign data_phase = (phase == PH_DATA);

  // R1: a command can only leave the opcode phase towards an address
  // phase with a lane mode picked, or be skipped without one.
  p_addr_has_mode_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADDR) |-> (mode != LM_NONE));
endmodule

// File: rtl/qread_lane_shift.sv
module qread_lane_shift
  import qread_pkg::*;
#(
  parameter int ADDR_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_s,
  input  logic                 fall,
  input  logic                 data_phase,
  input  lane_mode_t           mode,
  input  logic                 start,
  input  logic [ADDR_BITS-1:0] start_addr,
  input  logic [7:0]           rd_data,
  output logic                 rd_req,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic [3:0]           pin_out,
  output logic [3:0]           pin_oe
);
  logic [1:0] grp;
  logic [7:0] cur_byte;
  logic [7:0] next_byte;
  logic       req_d;
  logic [7:0] src;

  assign src = (grp == 2'd0) ? next_byte : cur_byte;

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      grp     <= 2'd0;
      rd_req  <= 1'b0;
      req_d   <= 1'b0;
      pin_out <= 4'b0000;
      pin_oe  <= 4'b0000;
      if (rst) begin
        rd_addr   <= '0;
        cur_byte  <= '0;
        next_byte <= '0;
      end
    end else begin
      rd_req <= 1'b0;
      req_d  <= rd_req;
      if (req_d) next_byte <= rd_data;
      if (start) begin
        rd_addr <= start_addr;
        rd_req  <= 1'b1;
      end
      if (fall && data_phase) begin
        if (grp == 2'd0) begin
          cur_byte <= next_byte;
          rd_addr  <= rd_addr + 1'b1;
          rd_req   <= 1'b1;
        end
        pin_out <= lane_slice(src, grp, mode);
        pin_oe  <= oe_mask(mode);
        grp     <= (grp == last_group(mode)) ? 2'd0 : grp + 2'd1;
      end
    end
  end

  // R4: only the two lane patterns may ever be enabled.
  p_oe_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (pin_oe == 4'b0000) || (pin_oe == 4'b0011) || (pin_oe == 4'b1111));

  // R8: a deselected bus is released on the next cycle.
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (pin_oe == 4'b0000));

  // R7: each byte fetch is a single-cycle request.
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
endmodule

// File: rtl/qread_lane_io.sv
module qread_lane_io
  import qread_pkg::*;
#(
  parameter int ADDR_BITS   = 24,
  parameter int DUMMY_CYC   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 quad_en,
  input  logic                 spi_sck,
  input  logic                 spi_cs_n,
  input  logic [3:0]           pin_in,
  output logic [3:0]           pin_out,
  output logic [3:0]           pin_oe,
  output logic                 wp_n_eff,
  output logic                 hold_n_eff,
  output logic                 rd_req,
  output logic [ADDR_BITS-1:0] rd_addr,
  input  logic [7:0]           rd_data
);
  localparam int SW = 6;

  logic [SW-1:0]        raw_bus;
  logic [SW-1:0]        syn_bus;
  logic                 sck_s, cs_s, sck_prev, rise, fall;
  logic [3:0]           pins_s;
  lane_mode_t           mode;
  logic                 data_phase, start;
  logic [ADDR_BITS-1:0] start_addr;

  assign raw_bus = {spi_cs_n, spi_sck, pin_in};

  qread_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(6'b10_0000)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus)
  );

  assign cs_s   = syn_bus[5];
  assign sck_s  = syn_bus[4];
  assign pins_s = syn_bus[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev   <= 1'b0;
      wp_n_eff   <= 1'b1;
      hold_n_eff <= 1'b1;
    end else begin
      sck_prev   <= sck_s;
      wp_n_eff   <= quad_en ? 1'b1 : pins_s[2];
      hold_n_eff <= quad_en ? 1'b1 : pins_s[3];
    end
  end

  assign rise = sck_s & ~sck_prev;
  assign fall = ~sck_s & sck_prev;

  qread_cmd_track #(.ADDR_BITS(ADDR_BITS), .DUMMY_CYC(DUMMY_CYC)) u_track (
    .clk(clk), .rst(rst), .cs_s(cs_s), .rise(rise), .lanes(pins_s),
    .quad_en(quad_en), .mode(mode), .data_phase(data_phase),
    .start(start), .start_addr(start_addr)
  );

  qread_lane_shift #(.ADDR_BITS(ADDR_BITS)) u_shift (
    .clk(clk), .rst(rst), .cs_s(cs_s), .fall(fall), .data_phase(data_phase),
    .mode(mode), .start(start), .start_addr(start_addr), .rd_data(rd_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // R1, R2: with no lane mode in force, the pins stay undriven.
  p_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_NONE) |=> (pin_oe == 4'b0000));

  // R9: while four lanes are enabled the repurposed pins read as inactive.
  p_wp_hold_off_r9: assert property (@(posedge clk) disable iff (rst)
    $past(quad_en) |-> (wp_n_eff && hold_n_eff));
endmodule

// File: tb/qread_lane_io_test.sv
module qread_lane_io_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        quad_en = 1'b0;
  logic        spi_sck = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic [3:0]  pin_in = 4'b0000;
  logic [3:0]  pin_out, pin_oe;
  logic        wp_n_eff, hold_n_eff, rd_req;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data = 8'h00;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qread_lane_io uut (
    .clk(clk), .rst(rst), .quad_en(quad_en), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .wp_n_eff(wp_n_eff),
    .hold_n_eff(hold_n_eff), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
  endfunction

  // Byte source: data one cycle after the request (R7).
  always_ff @(posedge clk) if (rd_req) rd_data <= mem_f(rd_addr);

  function automatic int data_lanes(input logic [7:0] op, input logic qe);
    if (op == 8'h3B || op == 8'hBB) return 2;
    if (qe && (op == 8'h6B || op == 8'hEB || op == 8'hE7 || op == 8'hE3)) return 4;
    return 0;
  endfunction

  function automatic int addr_lanes(input logic [7:0] op);
    if (op == 8'hBB) return 2;
    if (op == 8'hEB || op == 8'hE7 || op == 8'hE3) return 4;
    return 1;
  endfunction

  function automatic bit is_quad_op(input logic [7:0] op);
    return op == 8'h6B || op == 8'hEB || op == 8'hE7 || op == 8'hE3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_cycle(input logic [3:0] drive, output logic [3:0] s_out,
                           output logic [3:0] s_oe);
    pin_in = drive;
    wait_clk(HALF);
    s_out = pin_out;
    s_oe  = pin_oe;
    spi_sck = 1'b1;
    wait_clk(HALF);
    spi_sck = 1'b0;
  endtask

  // abort_at < 0: run all groups; otherwise deselect after that many groups.
  task automatic run_cmd(input logic [7:0] op, input logic [23:0] addr, input logic qe,
                         input int nbytes, input int abort_at);
    logic [3:0] so, soe, exp_l, mask;
    logic [7:0] b, sh;
    int dl, al, ng, groups_done, shamt;
    string tag;
    dl = data_lanes(op, qe);
    al = addr_lanes(op);
    quad_en = qe;
    wait_clk(2);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 7; i >= 0; i--) begin
      sck_cycle({3'b000, op[i]}, so, soe);
      chk(soe == 4'b0000, "R4 opcode phase", soe, 0);
    end
    if (dl == 0) begin
      tag = (is_quad_op(op) && !qe) ? "R2 quad blocked" : "R1 unlisted code";
      for (int c = 0; c < 24 + 8 + 8; c++) begin
        sck_cycle(4'($urandom), so, soe);
        chk(soe == 4'b0000, tag, soe, 0);
      end
    end else begin
      for (int c = 0; c < 24 / al; c++) begin
        shamt = 24 - al * (c + 1);
        sck_cycle(4'((addr >> shamt) & ((1 << al) - 1)), so, soe);
        chk(soe == 4'b0000, "R3 address phase", soe, 0);
      end
      for (int c = 0; c < 8; c++) begin
        sck_cycle(4'b0000, so, soe);
        chk(soe == 4'b0000, "R4 dummy phase", soe, 0);
      end
      ng = (dl == 2) ? 4 : 2;
      mask = (dl == 2) ? 4'b0011 : 4'b1111;
      groups_done = 0;
      for (int k = 0; k < nbytes; k++) begin
        b = mem_f(24'(addr + 24'(k)));
        for (int g = 0; g < ng; g++) begin
          if (abort_at >= 0 && groups_done == abort_at) break;
          sck_cycle(4'b0000, so, soe);
          sh = b << (g * dl);
          exp_l = (dl == 2) ? {2'b00, sh[7:6]} : sh[7:4];
          tag = (dl == 2) ? "R5 dual lanes" : "R6 quad lanes";
          if (k > 0) tag = {tag, " R7 next byte"};
          chk(soe == mask, "R4 output enable", soe, mask);
          chk((so & mask) == exp_l, tag, so & mask, exp_l);
          groups_done++;
        end
      end
    end
    spi_cs_n = 1'b1;
    wait_clk(4);
    chk(pin_oe == 4'b0000, "R8 release", pin_oe, 0);
    wait_clk(HALF);
  endtask

  initial begin
    logic [7:0] ops [10];
    ops = '{8'h3B, 8'hBB, 8'h6B, 8'hEB, 8'hE7, 8'hE3, 8'h0B, 8'h03, 8'h05, 8'hBB};
    void'($urandom(32'd20240));
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    chk(pin_oe == 4'b0000, "R4 reset oe", pin_oe, 0);
    chk(rd_req == 1'b0, "R7 reset req", rd_req, 0);

    // R9: effective write-protect and hold
    quad_en = 1'b0; pin_in = 4'b0000; wait_clk(4);
    chk(wp_n_eff == 1'b0, "R9 wp follows pin", wp_n_eff, 0);
    chk(hold_n_eff == 1'b0, "R9 hold follows pin", hold_n_eff, 0);
    quad_en = 1'b1; wait_clk(4);
    chk(wp_n_eff == 1'b1, "R9 wp forced off", wp_n_eff, 1);
    chk(hold_n_eff == 1'b1, "R9 hold forced off", hold_n_eff, 1);
    quad_en = 1'b0; pin_in = 4'b1000; wait_clk(4);
    chk(hold_n_eff == 1'b1 && wp_n_eff == 1'b0, "R9 mixed pins",
        {hold_n_eff, wp_n_eff}, 2'b10);

    // Directed commands
    run_cmd(8'h3B, 24'h123456, 1'b0, 3, -1);   // R1 R3 R5
    run_cmd(8'hBB, 24'hA5C3F0, 1'b0, 3, -1);   // R3 two-lane address
    run_cmd(8'h6B, 24'h00FF10, 1'b1, 3, -1);   // R6
    run_cmd(8'hEB, 24'h7E8001, 1'b1, 3, -1);   // R3 four-lane address
    run_cmd(8'hE7, 24'h000000, 1'b1, 2, -1);
    run_cmd(8'hE3, 24'h3C3C3C, 1'b1, 2, -1);
    run_cmd(8'hEB, 24'h111111, 1'b0, 2, -1);   // R2
    run_cmd(8'h6B, 24'h222222, 1'b0, 2, -1);   // R2
    run_cmd(8'h0B, 24'h333333, 1'b1, 2, -1);   // R1 unlisted
    run_cmd(8'h3B, 24'hFFFFFF, 1'b0, 3, -1);   // R7 address wrap
    run_cmd(8'hEB, 24'hFFFFFE, 1'b1, 3, -1);   // R7 wrap on four lanes
    run_cmd(8'hBB, 24'h456789, 1'b0, 2, 1);    // R8 abort mid byte
    run_cmd(8'h6B, 24'h456789, 1'b1, 2, 3);    // R8 abort mid byte
    run_cmd(8'h3B, 24'h0ABCDE, 1'b0, 2, -1);   // R8 clean restart

    // Random commands
    for (int t = 0; t < 24; t++) begin
      run_cmd(ops[$urandom_range(9, 0)], 24'($urandom), 1'($urandom),
              int'($urandom_range(4, 1)), -1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule